// File: doc/BRIEF.md
# Device Lifecycle State Controller

This block holds the security lifecycle stage of a device and is the only place where that stage may change. After reset it starts from a stage code read from non-volatile storage. It then accepts move requests from a configuration port and checks each one against a fixed directed graph of allowed moves. One stage is terminal. Rewinding a protected device needs a prior success strobe from an external credential verifier. The rewind picks its landing stage from a type bit and pulses an increment to an external anti-replay epoch counter.

From the current stage and any active temporary debug grant, the block derives its policy outputs: full debug, non-secure-only debug, permission to run user code, and permission to bulk-erase flash. A temporary debug grant is also authenticated. It widens debug access in the sealed stages without touching the stored stage, and reset drops it. Refused requests leave the stage as it was and raise a sticky error flag, which a clear request on the same port lowers.

Stage codes: 0 open, 1 setup, 2 setup-done, 3 partly sealed (secure side fixed, non-secure side debuggable), 4 sealed, 5 frozen, 6 rewind. Request kinds on `req_kind_i`: 0 move to `req_target_i`, 1 grant temporary full debug, 2 grant temporary non-secure debug, 3 clear the error flag.

Top module: `lcs_ctrl`

## Requirements
- R1: While `rst_ni` is low, `state_o` shows `nv_state_i`, except that codes 6 and 7 load frozen (5). The error flag, stored credential and temporary debug grant all reset to 0.
- R2: From open (0), a move request is accepted only with target 1 or 2.
- R3: From setup (1) or setup-done (2), a move request is accepted only with target 3, 4, 5 or 6.
- R4: From partly sealed (3), a move request is accepted only with target 4, 5 or 6. From sealed (4), it is accepted only with target 6.
- R5: In frozen (5), every move and debug-grant request is refused, and the stage never leaves 5.
- R6: A refused request leaves `state_o` unchanged after the clock edge and sets `err_o`. `err_o` stays high until a request of kind 3, and is low after the edge that takes that request.
- R7: A move to rewind (6) is accepted only if an `auth_ok_i` strobe was seen on an earlier edge since reset and has not yet been used. An accepted rewind uses up the credential.
- R8: Rewind lasts exactly one cycle. It then lands on open (0) if `req_full_i` was 1 with the request, or on partly sealed (3) if it was 0. `epoch_inc_o` is high in that one rewind cycle only.
- R9: Without a temporary grant, `dbg_full_o` is 1 in stages 0, 1 and 2, `dbg_ns_o` is 1 only in stage 3, and both are 0 in stages 4, 5 and 6. The two outputs are never high together.
- R10: A debug-grant request (kind 1 or 2) is accepted only in stage 3 or 4 with a stored credential. In those stages it then drives `dbg_full_o` (kind 1) or `dbg_ns_o` (kind 2, when full is not active). It leaves `state_o` unchanged, and reset clears it.
- R11: `user_exec_o` is 0 in setup (1) and rewind (6), and 1 in every other stage.
- R12: `erase_ok_o` is 1 in stages 0, 2 and 3. In sealed (4) it equals "a stored credential is present". It is 0 in stages 1, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nv_state_i | input | 3 | Stage code from non-volatile storage, loaded during reset |
| req_valid_i | input | 1 | Request strobe from the configuration port |
| req_kind_i | input | 2 | Request kind: 0 move, 1 full debug grant, 2 non-secure debug grant, 3 clear error |
| req_target_i | input | 3 | Target stage code of a move request |
| req_full_i | input | 1 | Rewind type with a move to 6: 1 lands on open, 0 lands on partly sealed |
| auth_ok_i | input | 1 | Success strobe from the external credential verifier |
| state_o | output | 3 | Current stage code |
| dbg_full_o | output | 1 | Full debug access enabled |
| dbg_ns_o | output | 1 | Non-secure-only debug access enabled |
| user_exec_o | output | 1 | User code may execute |
| erase_ok_o | output | 1 | Bulk flash erase permitted |
| epoch_inc_o | output | 1 | One-cycle increment pulse for the epoch counter |
| err_o | output | 1 | Sticky refused-request flag |

## Verification
The move graph is swept in full. Every reachable start stage is loaded through reset, and every one of the eight target codes is requested, each with and without a prior credential strobe. This separates a wrong edge in the graph from a missing credential check on rewind, and the two rewind types show whether the landing stage follows the type bit. Separate sequences use up a credential and then try to rewind again. They also request debug grants in permitted and forbidden stages, and reset with a grant active. These runs tell a grant that leaks across reset or into the stored stage apart from one that is simply refused.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

    localparam int LC_W   = 3;
    localparam int LC_NUM = 2 ** LC_W;
    localparam int RQ_W   = 2;

    typedef enum logic [LC_W-1:0] {
        LC_OPEN       = 3'd0,
        LC_SETUP      = 3'd1,
        LC_SETUP_DONE = 3'd2,
        LC_NS_DEV     = 3'd3,
        LC_SEALED     = 3'd4,
        LC_FROZEN     = 3'd5,
        LC_REWIND     = 3'd6
    } lc_state_e;

    typedef enum logic [RQ_W-1:0] {
        RQ_MOVE     = 2'd0,
        RQ_DBG_FULL = 2'd1,
        RQ_DBG_NS   = 2'd2,
        RQ_ERR_CLR  = 2'd3
    } rq_kind_e;

    typedef struct packed {
        lc_state_e st;
        logic      rgn_full;
        logic      auth;
        logic      reo_full;
        logic      reo_ns;
        logic      err;
    } lc_regs_t;

    // Stored codes that are not stable stages fall back to the terminal stage.
    function automatic lc_state_e lc_sanitize(input logic [LC_W-1:0] raw);
        if (raw >= LC_W'(LC_REWIND)) return LC_FROZEN;
        return lc_state_e'(raw);
    endfunction

    function automatic logic [LC_NUM-1:0] lc_bit(input lc_state_e s);
        return {{(LC_NUM-1){1'b0}}, 1'b1} << s;
    endfunction

endpackage

// File: rtl/lcs_graph.sv
module lcs_graph
    import lcs_pkg::*;
(
    input  lc_state_e         cur_i,
    input  logic [LC_W-1:0]   tgt_i,
    output logic              edge_ok_o
);

    logic [LC_NUM-1:0] allow_mask;

    always_comb begin
        case (cur_i)
            LC_OPEN:       allow_mask = lc_bit(LC_SETUP) | lc_bit(LC_SETUP_DONE);
            LC_SETUP,
            LC_SETUP_DONE: allow_mask = lc_bit(LC_NS_DEV) | lc_bit(LC_SEALED)
                                      | lc_bit(LC_FROZEN) | lc_bit(LC_REWIND);
            LC_NS_DEV:     allow_mask = lc_bit(LC_SEALED) | lc_bit(LC_FROZEN)
                                      | lc_bit(LC_REWIND);
            LC_SEALED:     allow_mask = lc_bit(LC_REWIND);
            default:       allow_mask = '0;
        endcase
    end

    assign edge_ok_o = allow_mask[tgt_i];

endmodule

// File: rtl/lcs_decode.sv
module lcs_decode
    import lcs_pkg::*;
(
    input  lc_state_e st_i,
    input  logic      auth_i,
    input  logic      reo_full_i,
    input  logic      reo_ns_i,
    output logic      dbg_full_o,
    output logic      dbg_ns_o,
    output logic      user_exec_o,
    output logic      erase_ok_o,
    output logic      epoch_inc_o
);

    logic base_full;
    logic base_ns;
    logic grant_zone;

    always_comb begin
        base_full   = 1'b0;
        base_ns     = 1'b0;
        user_exec_o = 1'b1;
        erase_ok_o  = 1'b0;
        case (st_i)
            LC_OPEN:       begin base_full = 1'b1; erase_ok_o = 1'b1; end
            LC_SETUP:      begin base_full = 1'b1; user_exec_o = 1'b0; end
            LC_SETUP_DONE: begin base_full = 1'b1; erase_ok_o = 1'b1; end
            LC_NS_DEV:     begin base_ns = 1'b1; erase_ok_o = 1'b1; end
            LC_SEALED:     erase_ok_o = auth_i;
            LC_REWIND:     user_exec_o = 1'b0;
            default:       ;
        endcase
    end

    assign grant_zone  = (st_i == LC_NS_DEV) || (st_i == LC_SEALED);
    assign dbg_full_o  = base_full | (grant_zone & reo_full_i);
    assign dbg_ns_o    = ~dbg_full_o & (base_ns | (grant_zone & reo_ns_i));
    assign epoch_inc_o = (st_i == LC_REWIND);

endmodule

// File: rtl/lcs_ctrl.sv
module lcs_ctrl
    import lcs_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [2:0]  nv_state_i,
    input  logic        req_valid_i,
    input  logic [1:0]  req_kind_i,
    input  logic [2:0]  req_target_i,
    input  logic        req_full_i,
    input  logic        auth_ok_i,
    output logic [2:0]  state_o,
    output logic        dbg_full_o,
    output logic        dbg_ns_o,
    output logic        user_exec_o,
    output logic        erase_ok_o,
    output logic        epoch_inc_o,
    output logic        err_o
);

    lc_regs_t r_d, r_q, r_rst;
    logic     edge_ok;
    logic     grant_ok;
    rq_kind_e kind;

    assign kind = rq_kind_e'(req_kind_i);

    lcs_graph u_graph (
        .cur_i     (r_q.st),
        .tgt_i     (req_target_i),
        .edge_ok_o (edge_ok)
    );

    assign grant_ok = r_q.auth && ((r_q.st == LC_NS_DEV) || (r_q.st == LC_SEALED));

    always_comb begin
        r_rst          = '0;
        r_rst.st       = lc_sanitize(nv_state_i);
    end

    always_comb begin
        r_d = r_q;
        if (auth_ok_i) r_d.auth = 1'b1;
        if (r_q.st == LC_REWIND) begin
            r_d.st = r_q.rgn_full ? LC_OPEN : LC_NS_DEV;
        end
        if (req_valid_i) begin
            case (kind)
                RQ_MOVE: begin
                    if (edge_ok && (req_target_i != LC_W'(LC_REWIND) || r_q.auth)) begin
                        r_d.st = lc_state_e'(req_target_i);
                        if (req_target_i == LC_W'(LC_REWIND)) begin
                            r_d.rgn_full = req_full_i;
                            r_d.auth     = 1'b0;
                        end
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
                RQ_DBG_FULL: begin
                    if (grant_ok) r_d.reo_full = 1'b1;
                    else          r_d.err      = 1'b1;
                end
                RQ_DBG_NS: begin
                    if (grant_ok) r_d.reo_ns = 1'b1;
                    else          r_d.err    = 1'b1;
                end
                default: r_d.err = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= r_rst;
        else         r_q <= r_d;
    end

    lcs_decode u_decode (
        .st_i        (r_q.st),
        .auth_i      (r_q.auth),
        .reo_full_i  (r_q.reo_full),
        .reo_ns_i    (r_q.reo_ns),
        .dbg_full_o  (dbg_full_o),
        .dbg_ns_o    (dbg_ns_o),
        .user_exec_o (user_exec_o),
        .erase_ok_o  (erase_ok_o),
        .epoch_inc_o (epoch_inc_o)
    );

    assign state_o = r_q.st;
    assign err_o   = r_q.err;

endmodule

// File: rtl/lcs_ctrl_chk.sv
module lcs_ctrl_chk
    import lcs_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic       req_valid_i,
    input logic [1:0] req_kind_i,
    input logic [2:0] state_o,
    input logic       dbg_full_o,
    input logic       dbg_ns_o,
    input logic       user_exec_o,
    input logic       epoch_inc_o,
    input logic       err_o
);

    logic clr_req;
    assign clr_req = req_valid_i && (req_kind_i == 2'd3);

    a_r2_open_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == LC_OPEN |=> (state_o == LC_OPEN || state_o == LC_SETUP
                                || state_o == LC_SETUP_DONE));

    a_r4_sealed_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == LC_SEALED |=> (state_o == LC_SEALED || state_o == LC_REWIND));

    a_r5_frozen_terminal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == LC_FROZEN |=> state_o == LC_FROZEN);

    a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_o && !clr_req) |=> err_o);

    a_r6_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_req |=> !err_o);

    a_r8_rewind_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == LC_REWIND |=> (state_o == LC_OPEN || state_o == LC_NS_DEV));

    a_r8_epoch_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        epoch_inc_o |=> !epoch_inc_o);

    a_r9_dbg_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(dbg_full_o && dbg_ns_o));

    a_r11_setup_no_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == LC_SETUP |-> !user_exec_o);

endmodule

bind lcs_ctrl lcs_ctrl_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_kind_i  (req_kind_i),
    .state_o     (state_o),
    .dbg_full_o  (dbg_full_o),
    .dbg_ns_o    (dbg_ns_o),
    .user_exec_o (user_exec_o),
    .epoch_inc_o (epoch_inc_o),
    .err_o       (err_o)
);

// File: tb/lcs_ctrl_tb.sv
`timescale 1ns/1ps
module lcs_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic [2:0] nv_state_i = 3'd0;
    logic       req_valid_i = 1'b0;
    logic [1:0] req_kind_i = 2'd0;
    logic [2:0] req_target_i = 3'd0;
    logic       req_full_i = 1'b0;
    logic       auth_ok_i = 1'b0;
    logic [2:0] state_o;
    logic       dbg_full_o, dbg_ns_o, user_exec_o, erase_ok_o, epoch_inc_o, err_o;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    lcs_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .nv_state_i(nv_state_i),
        .req_valid_i(req_valid_i), .req_kind_i(req_kind_i),
        .req_target_i(req_target_i), .req_full_i(req_full_i),
        .auth_ok_i(auth_ok_i), .state_o(state_o), .dbg_full_o(dbg_full_o),
        .dbg_ns_o(dbg_ns_o), .user_exec_o(user_exec_o), .erase_ok_o(erase_ok_o),
        .epoch_inc_o(epoch_inc_o), .err_o(err_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit edge_allowed(input int s, input int t);
        case (s)
            0:       return (t == 1) || (t == 2);
            1, 2:    return (t >= 3) && (t <= 6);
            3:       return (t >= 4) && (t <= 6);
            4:       return t == 6;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int exp_erase(input int s, input bit cred);
        case (s)
            0, 2, 3: return 1;
            4:       return int'(cred);
            default: return 0;
        endcase
    endfunction

    task automatic do_reset(input int s);
        @(negedge clk);
        rst_ni = 1'b0; nv_state_i = 3'(s); req_valid_i = 1'b0; auth_ok_i = 1'b0;
        @(negedge clk);
        rst_ni = 1'b1;
        #0.5;
    endtask

    task automatic give_auth();
        auth_ok_i = 1'b1;
        @(negedge clk);
        auth_ok_i = 1'b0;
        #0.5;
    endtask

    task automatic send(input int kind, input int tgt, input bit full);
        req_valid_i = 1'b1; req_kind_i = 2'(kind);
        req_target_i = 3'(tgt); req_full_i = full;
        @(negedge clk);
        req_valid_i = 1'b0;
        #0.5;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1, R9, R11, R12: reset load and per-stage policy table
        for (int s = 0; s < 8; s++) begin
            int e;
            e = (s >= 6) ? 5 : s;
            do_reset(s);
            chk("R1 reset stage", state_o, e);
            chk("R1 reset err", err_o, 0);
            chk("R9 dbg full", dbg_full_o, (e <= 2) ? 1 : 0);
            chk("R9 dbg ns", dbg_ns_o, (e == 3) ? 1 : 0);
            chk("R11 user exec", user_exec_o, (e == 1) ? 0 : 1);
            chk("R12 erase", erase_ok_o, exp_erase(e, 1'b0));
            chk("R8 epoch idle", epoch_inc_o, 0);
        end
        do_reset(4);
        give_auth();
        chk("R12 erase sealed with credential", erase_ok_o, 1);

        // R2..R8: full move graph sweep
        for (int s = 0; s < 6; s++) begin
            for (int t = 0; t < 8; t++) begin
                for (int a = 0; a < 2; a++) begin
                    bit ok;
                    bit full;
                    full = ((s + t) % 2) == 0;
                    ok = edge_allowed(s, t) && ((t != 6) || (a == 1));
                    do_reset(s);
                    if (a == 1) give_auth();
                    send(0, t, full);
                    if (ok) begin
                        chk(s == 0 ? "R2 legal move" : (s <= 2 ? "R3 legal move" : "R4 legal move"),
                            state_o, t);
                        chk("R6 no err on legal", err_o, 0);
                        if (t == 6) begin
                            chk("R8 epoch pulse", epoch_inc_o, 1);
                            chk("R11 no exec in rewind", user_exec_o, 0);
                            @(negedge clk); #0.5;
                            chk("R8 rewind landing", state_o, full ? 0 : 3);
                            chk("R8 epoch ends", epoch_inc_o, 0);
                        end
                    end else begin
                        chk(s == 5 ? "R5 frozen refuses" :
                            ((t == 6 && a == 0 && edge_allowed(s, t)) ? "R7 rewind needs credential"
                                                                      : "R6 illegal keeps stage"),
                            state_o, s);
                        chk("R6 err raised", err_o, 1);
                        @(negedge clk); #0.5;
                        chk("R6 err sticky", err_o, 1);
                        send(3, 0, 1'b0);
                        chk("R6 err cleared", err_o, 0);
                    end
                end
            end
        end

        // R7: credential used up by a rewind
        do_reset(2);
        give_auth();
        send(0, 6, 1'b0);
        @(negedge clk); #0.5;
        chk("R7 landed partly sealed", state_o, 3);
        send(0, 6, 1'b1);
        chk("R7 second rewind refused", state_o, 3);
        chk("R7 err on reused credential", err_o, 1);

        // R10: temporary debug grants
        do_reset(4);
        send(1, 0, 1'b0);
        chk("R10 grant without credential", dbg_full_o, 0);
        chk("R10 grant refused err", err_o, 1);
        send(3, 0, 1'b0);
        give_auth();
        send(2, 0, 1'b0);
        chk("R10 ns grant", dbg_ns_o, 1);
        chk("R10 ns grant not full", dbg_full_o, 0);
        chk("R10 stage unchanged", state_o, 4);
        send(1, 0, 1'b0);
        chk("R10 full grant", dbg_full_o, 1);
        chk("R9 exclusive", dbg_ns_o, 0);
        chk("R10 stage unchanged full", state_o, 4);
        do_reset(4);
        chk("R10 grant cleared by reset", dbg_full_o, 0);
        chk("R10 ns cleared by reset", dbg_ns_o, 0);

        do_reset(3);
        give_auth();
        send(1, 0, 1'b0);
        chk("R10 full grant partly sealed", dbg_full_o, 1);
        send(0, 5, 1'b0);
        chk("R5 moved to frozen", state_o, 5);
        chk("R5 grant masked in frozen", dbg_full_o, 0);

        do_reset(5);
        give_auth();
        send(1, 0, 1'b0);
        chk("R5 frozen grant refused", dbg_full_o, 0);
        chk("R5 frozen grant err", err_o, 1);

        do_reset(0);
        give_auth();
        send(2, 0, 1'b0);
        chk("R10 grant refused in open", err_o, 1);
        chk("R10 open stage kept", state_o, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule